// File: doc/BRIEF.md
# Base and Bound Address Translator

This block sits between a simple pipelined processor and its memory path. It relocates each logical address by adding a base value and checks the address against a bound value. Instruction fetch and data access each have their own base and bound pair. A fetch address is translated and checked against the fetch pair. A data address arrives as a source register value plus an immediate. The block adds that sum to the data base in a single three-operand step, built as a carry-save stage followed by one carry-propagate adder. The bound check uses the untranslated logical address.

When an access is out of range, the block raises a violation flag for that port and holds back the outgoing request strobe. No out-of-segment access reaches memory. The four registers are written and read through a small configuration port, and only supervisor mode may use it. A write attempted in user mode changes nothing and raises a privilege-fault output. The translation path is purely combinational. Register writes take effect at the next clock edge. A synchronous reset clears all four registers to zero.

Top module: `bb_xlate`

## Requirements
- R1: The fetch physical address equals the fetch logical address plus the fetch base, modulo 2^32, in the same cycle.
- R2: The data logical address is source value plus immediate (modulo 2^32). The data physical address equals source plus immediate plus data base, modulo 2^32, including cases where the sum wraps.
- R3: The fetch violation flag is high exactly when a fetch request is present and the fetch logical address is greater than the fetch bound. An address equal to the bound is legal.
- R4: The data violation flag is high exactly when a data request is present and the data logical address (not the physical one) is greater than the data bound. An address equal to the bound is legal.
- R5: Each outgoing request strobe equals its incoming request with the violation flag cleared. With no request present, neither violation flag is raised.
- R6: A supervisor-mode write (sup_mode=1, cfg_we=1) updates the register picked by cfg_sel at the next clock edge. The selector encoding is 0 = fetch base, 1 = fetch bound, 2 = data base, 3 = data bound.
- R7: A write attempted with sup_mode=0 leaves all four registers unchanged. During that cycle priv_fault is 1. priv_fault is 0 in every other cycle.
- R8: In supervisor mode, cfg_rdata returns the register picked by cfg_sel. In user mode, cfg_rdata is zero.
- R9: A synchronous reset clears all four registers to zero. After reset, only logical address 0 passes either bound check, and physical equals logical.
- R10: The fetch pair and the data pair are independent. Writing one pair leaves the other pair's translation and checks unchanged. In the same cycle, a single address can be legal on one port and a violation on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_mode | input | 1 | Processor is in supervisor mode |
| cfg_we | input | 1 | Configuration write request |
| cfg_sel | input | 2 | Register selector (0 fetch base, 1 fetch bound, 2 data base, 3 data bound) |
| cfg_wdata | input | AW | Configuration write value |
| cfg_rdata | output | AW | Selected register value, zero in user mode |
| priv_fault | output | 1 | User-mode write attempt |
| f_req | input | 1 | Fetch request |
| f_laddr | input | AW | Fetch logical address |
| f_paddr | output | AW | Fetch physical address |
| f_viol | output | 1 | Fetch bound violation |
| f_req_out | output | 1 | Fetch request passed to memory |
| d_req | input | 1 | Data request |
| d_rs1 | input | AW | Data source register value |
| d_imm | input | AW | Data immediate, sign-extended |
| d_paddr | output | AW | Data physical address |
| d_viol | output | 1 | Data bound violation |
| d_req_out | output | 1 | Data request passed to memory |

## Verification
The bench tests addresses exactly at the bound and one above it on both ports. A design that used "less than" would reject the bound itself, and one that checked the physical address would misjudge relocated accesses. It uses negative immediates and bases that wrap past 2^32. This exposes a carry-save stage that drops or misplaces its shifted carry, or loses the top bit. It also writes in user mode and then reads back in supervisor mode, and it places the same address on both ports at once. These catch a design that honours unprivileged writes, swaps the pairs, or lets a violating request through to memory.

// File: rtl/bb_xlate.sv
module bb_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup_mode,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          priv_fault,
  input  logic          f_req,
  input  logic [AW-1:0] f_laddr,
  output logic [AW-1:0] f_paddr,
  output logic          f_viol,
  output logic          f_req_out,
  input  logic          d_req,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_imm,
  output logic [AW-1:0] d_paddr,
  output logic          d_viol,
  output logic          d_req_out
);

  logic [AW-1:0] f_base, f_bound, d_base, d_bound;
  logic [AW-1:0] d_laddr, csa_s, csa_c;
  logic          wr_ok;

  assign wr_ok      = cfg_we && sup_mode;
  assign priv_fault = cfg_we && !sup_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_base  <= '0;
      f_bound <= '0;
      d_base  <= '0;
      d_bound <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        2'd0: f_base  <= cfg_wdata;
        2'd1: f_bound <= cfg_wdata;
        2'd2: d_base  <= cfg_wdata;
        default: d_bound <= cfg_wdata;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sup_mode) begin
      case (cfg_sel)
        2'd0: cfg_rdata = f_base;
        2'd1: cfg_rdata = f_bound;
        2'd2: cfg_rdata = d_base;
        default: cfg_rdata = d_bound;
      endcase
    end
  end

  assign f_paddr   = f_laddr + f_base;
  assign f_viol    = f_req && (f_laddr > f_bound);
  assign f_req_out = f_req && !f_viol;

  assign csa_s = d_rs1 ^ d_imm ^ d_base;
  assign csa_c = {(d_rs1[AW-2:0] & d_imm[AW-2:0]) |
                  (d_rs1[AW-2:0] & d_base[AW-2:0]) |
                  (d_imm[AW-2:0] & d_base[AW-2:0]), 1'b0};
  assign d_paddr = csa_s + csa_c;

  assign d_laddr   = d_rs1 + d_imm;
  assign d_viol    = d_req && (d_laddr > d_bound);
  assign d_req_out = d_req && !d_viol;

endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          sup_mode,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] cfg_rdata,
  input logic          priv_fault,
  input logic          f_req,
  input logic [AW-1:0] f_laddr,
  input logic          f_viol,
  input logic          f_req_out,
  input logic          d_req,
  input logic [AW-1:0] d_rs1,
  input logic [AW-1:0] d_imm,
  input logic [AW-1:0] d_paddr,
  input logic          d_viol,
  input logic          d_req_out,
  input logic [AW-1:0] f_base,
  input logic [AW-1:0] f_bound,
  input logic [AW-1:0] d_base,
  input logic [AW-1:0] d_bound
);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (f_base == '0 && f_bound == '0 && d_base == '0 && d_bound == '0));

  // R6
  sup_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sup_mode && cfg_sel == 2'd0) |=> f_base == $past(cfg_wdata));

  // R7
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !sup_mode) |=> ($stable(f_base) && $stable(f_bound) &&
                               $stable(d_base) && $stable(d_bound)));

  // R8
  user_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> cfg_rdata == '0);

  // R5
  f_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    f_req_out |-> (f_req && !f_viol));

  // R5
  d_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    d_req_out |-> (d_req && !d_viol));

  // R5
  no_req_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (!f_req |-> !f_viol) and (!d_req |-> !d_viol));

  // R2
  csa_sum_chk: assert property (@(posedge clk) disable iff (rst)
    d_paddr == AW'(d_rs1 + d_imm + d_base));

  // R3
  f_bound_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (f_req && f_laddr <= f_bound) |-> !f_viol);

endmodule

bind bb_xlate bb_xlate_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .priv_fault(priv_fault), .f_req(f_req), .f_laddr(f_laddr),
  .f_viol(f_viol), .f_req_out(f_req_out), .d_req(d_req), .d_rs1(d_rs1),
  .d_imm(d_imm), .d_paddr(d_paddr), .d_viol(d_viol), .d_req_out(d_req_out),
  .f_base(f_base), .f_bound(f_bound), .d_base(d_base), .d_bound(d_bound)
);

// File: tb/bb_xlate_test.sv
module bb_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sup_mode = 1'b1, cfg_we = 1'b0, f_req = 1'b0, d_req = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, f_laddr = '0, d_rs1 = '0, d_imm = '0;
  logic [31:0] cfg_rdata, f_paddr, d_paddr;
  logic        priv_fault, f_viol, f_req_out, d_viol, d_req_out;

  always #4 clk = ~clk;

  bb_xlate uut (
    .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .priv_fault(priv_fault), .f_req(f_req), .f_laddr(f_laddr),
    .f_paddr(f_paddr), .f_viol(f_viol), .f_req_out(f_req_out),
    .d_req(d_req), .d_rs1(d_rs1), .d_imm(d_imm), .d_paddr(d_paddr),
    .d_viol(d_viol), .d_req_out(d_req_out)
  );

  typedef struct {
    string       rq;
    logic [31:0] fp, dp, rd;
    logic        fv, fo, dv, dq, pf;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mb[4];
  logic        pend_rst = 1'b0, pend_we = 1'b0;
  logic [1:0]  pend_sel = 2'd0;
  logic [31:0] pend_wd = '0;
  int          checks = 0, fails = 0;

  task automatic cmp(input string rq, input string fld, input logic [31:0] act, input logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, fld, act, ex);
    end
  endtask

  task automatic step(input string rq, input logic r, input logic s, input logic we,
                      input logic [1:0] sel, input logic [31:0] wd,
                      input logic fr, input logic [31:0] fl,
                      input logic dr, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [31:0] dl;
    @(posedge clk); #1;
    if (pend_rst) foreach (mb[i]) mb[i] = '0;
    else if (pend_we) mb[pend_sel] = pend_wd;
    rst = r; sup_mode = s; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    f_req = fr; f_laddr = fl; d_req = dr; d_rs1 = a; d_imm = b;
    dl   = a + b;
    e.rq = rq;
    e.fp = fl + mb[0];
    e.dp = dl + mb[2];
    e.rd = s ? mb[sel] : 32'd0;
    e.fv = fr && (fl > mb[1]);
    e.fo = fr && !e.fv;
    e.dv = dr && (dl > mb[3]);
    e.dq = dr && !e.dv;
    e.pf = we && !s;
    q.push_back(e);
    pend_rst = r;
    pend_we  = we && s && !r;
    pend_sel = sel;
    pend_wd  = wd;
  endtask

  task automatic wr(input string rq, input logic [1:0] sel, input logic [31:0] wd);
    step(rq, 1'b0, 1'b1, 1'b1, sel, wd, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic rd(input string rq, input logic s, input logic [1:0] sel);
    step(rq, 1'b0, s, 1'b0, sel, '0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic fx(input string rq, input logic fr, input logic [31:0] fl);
    step(rq, 1'b0, 1'b1, 1'b0, 2'd0, '0, fr, fl, 1'b0, '0, '0);
  endtask

  task automatic dx(input string rq, input logic [31:0] a, input logic [31:0] b);
    step(rq, 1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, 1'b1, a, b);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.rq, "f_paddr", f_paddr, e.fp);
      cmp(e.rq, "d_paddr", d_paddr, e.dp);
      cmp(e.rq, "cfg_rdata", cfg_rdata, e.rd);
      cmp(e.rq, "f_viol", {31'd0, f_viol}, {31'd0, e.fv});
      cmp(e.rq, "f_req_out", {31'd0, f_req_out}, {31'd0, e.fo});
      cmp(e.rq, "d_viol", {31'd0, d_viol}, {31'd0, e.dv});
      cmp(e.rq, "d_req_out", {31'd0, d_req_out}, {31'd0, e.dq});
      cmp(e.rq, "priv_fault", {31'd0, priv_fault}, {31'd0, e.pf});
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    foreach (mb[i]) mb[i] = '0;
    step("R9", 1'b1, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, 1'b0, '0, '0);
    step("R9", 1'b1, 1'b1, 1'b0, 2'd1, '0, 1'b0, '0, 1'b0, '0, '0);
    step("R9", 1'b0, 1'b1, 1'b0, 2'd3, '0, 1'b1, 32'd0, 1'b1, 32'd0, 32'd0);
    step("R9", 1'b0, 1'b1, 1'b0, 2'd2, '0, 1'b1, 32'd1, 1'b1, 32'd5, 32'hFFFF_FFFC);

    wr("R6", 2'd0, 32'h1000_0000);
    wr("R6", 2'd1, 32'h0000_0FFF);
    wr("R6", 2'd2, 32'h2000_0000);
    wr("R6", 2'd3, 32'h0000_7FFF);
    for (int i = 0; i < 4; i++) rd("R8", 1'b1, 2'(i));
    rd("R8", 1'b0, 2'd1);

    fx("R1", 1'b1, 32'h0000_0123);
    fx("R3", 1'b1, 32'h0000_0FFF);
    fx("R3", 1'b1, 32'h0000_1000);
    fx("R5", 1'b0, 32'hFFFF_0000);

    dx("R2", 32'h0000_0100, 32'h0000_0020);
    dx("R4", 32'h0000_7000, 32'h0000_0FFF);
    dx("R4", 32'h0000_7000, 32'h0000_1000);
    dx("R2", 32'h0000_0010, 32'hFFFF_FFF0);
    dx("R4", 32'h0000_0000, 32'hFFFF_FFFF);

    step("R7", 1'b0, 1'b0, 1'b1, 2'd0, 32'hDEAD_BEEF, 1'b1, 32'h40, 1'b0, '0, '0);
    step("R7", 1'b0, 1'b0, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, '0, 1'b1, 32'h9000, 32'd0);
    rd("R7", 1'b1, 2'd0);
    rd("R7", 1'b1, 2'd3);
    fx("R7", 1'b1, 32'h40);

    step("R10", 1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b1, 32'h2000, 1'b1, 32'h1000, 32'h1000);
    wr("R10", 2'd2, 32'hFFFF_FF00);
    fx("R10", 1'b1, 32'h0000_0800);
    dx("R2", 32'h0000_0200, 32'h0000_0010);
    wr("R10", 2'd1, 32'hFFFF_FFFF);
    dx("R10", 32'h0000_8000, 32'd0);
    fx("R3", 1'b1, 32'hFFFF_FFFF);

    for (int i = 0; i < 60; i++)
      step("R6", 1'b0, 1'($urandom), 1'($urandom), 2'($urandom), $urandom,
           1'($urandom), $urandom >> ($urandom % 32),
           1'($urandom), $urandom >> ($urandom % 32), $urandom >> ($urandom % 32));

    step("R9", 1'b1, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, 1'b0, '0, '0);
    for (int i = 0; i < 4; i++) rd("R9", 1'b1, 2'(i));
    step("R9", 1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b1, 32'h10, 1'b1, 32'h0, 32'h0);

    @(posedge clk);
    @(negedge clk);
    #1;
    summary();
    $finish;
  end
endmodule